// File: doc/BRIEF.md
# Receive Descriptor DMA Channel

This block is one receive DMA channel. It moves words that arrive on a streaming input into memory buffers. The buffers are described by descriptors that software links into a chain in memory. Software places the address of the first descriptor in the current-pointer register and then writes a tail pointer. The tail write starts the engine. The engine fetches each descriptor and fills its buffer from the stream. It then writes the frame length and a status byte back into the descriptor. If that descriptor was not the one the tail names, the engine follows the next pointer.

A descriptor spans eight 32-bit words and begins on a 32-byte boundary. A frame that is larger than one buffer continues into the next descriptor of the chain. Start-of-packet and end-of-packet flags in the status byte mark where the frame begins and ends. A small register block gives software five pending event bits with per-bit enables and a sticky error flag. It also holds a global control word with a self-clearing soft reset.

Top module: `bd_rx_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `mem_req` is low.
- R2: The register word indices are: current pointer 0x0B, tail pointer 0x0C, event enable 0x0D, pending events 0x0E, status 0x0F, global control 0x10. Other indices read 0. The current pointer reads back what was written, except that writes to it are ignored while the engine is busy (status bit 1).
- R3: When the engine is idle and global control bit 2 (tail mode) is 1, a write to the tail pointer starts processing at the current pointer. When bit 2 is 0, a tail write starts nothing and status bit 1 stays 0.
- R4: Descriptor words are numbered from the descriptor address: word 0 is the next pointer, word 1 the buffer byte address, and word 2 the buffer length in bytes. The length sits in the low 14 bits, is a multiple of 4 and is at least 4. The fetch reads words 0 to 3.
- R5: Stream words are written to consecutive buffer words. A descriptor ends when its buffer is full or when a word with `s_last` has been stored. Buffer words after that point are left untouched.
- R6: Write-back happens in two steps. First, word 7 receives the frame byte count so far in its low 14 bits. Then word 3 bits 31:24 receive the status byte: 0x10 (completed), OR 0x08 if this descriptor began the frame, OR 0x04 if it ended the frame.
- R7: After the descriptor whose address equals the tail pointer, the engine stops and the current pointer keeps that address. After any other descriptor, the current pointer becomes word 0 and the engine goes on.
- R8: The pending-event bits are: bit 0 descriptor done, bit 1 frame done, bit 2 stopped at tail, bit 4 error. Writing a 1 to a bit clears it. `irq` is high when any pending bit has its enable bit set.
- R9: If the pointer about to be fetched is not 32-byte aligned, no memory access occurs. Status bit 7 and pending bit 4 set. The error is sticky and blocks all starts until a soft reset.
- R10: Writing 1 to global control bit 0 halts the engine and clears every register. Bit 0 then reads 1 for RST_CYCLES cycles and register writes are ignored during that time.
- R11: Global control bits 4:2 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register word index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_idx |
| irq | output | 1 | Enabled pending event present |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | DW | Memory byte address, word aligned |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | DW | Memory read data |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word taken this cycle |
| s_data | input | DW | Stream word |
| s_last | input | 1 | Stream word ends the frame |

## Verification
An engine that ends a descriptor one word late shows up within the same descriptor as a buffer word written past the frame end. An engine that ends it one word early shows up as a frame byte count in word 7 that is short by four. A corrupted start-of-packet state is visible right away in the status byte of the next descriptor, because the 0x08 flag moves to the wrong descriptor of a chained frame. A broken tail comparison shows up as a write to the descriptor beyond the tail, or as a current pointer that does not match the tail once the status register reports idle.

// File: rtl/bd_rx_dma_pkg.sv
`timescale 1ns/1ps
package bd_rx_dma_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_WBLEN, ST_WBSTS} eng_state_e;

  localparam int NUM_EVT   = 5;
  localparam int EV_DESC   = 0;
  localparam int EV_FRAME  = 1;
  localparam int EV_TAIL   = 2;
  localparam int EV_ERR    = 4;

  localparam logic [7:0] BD_DONE = 8'h10;
  localparam logic [7:0] BD_SOP  = 8'h08;
  localparam logic [7:0] BD_EOP  = 8'h04;

  localparam int BD_ALIGN_BITS = 5;
  localparam int OFS_STAT      = 12;
  localparam int OFS_LENW      = 28;

  localparam logic [4:0] IX_CUR  = 5'h0B;
  localparam logic [4:0] IX_TAIL = 5'h0C;
  localparam logic [4:0] IX_CTL  = 5'h0D;
  localparam logic [4:0] IX_PEND = 5'h0E;
  localparam logic [4:0] IX_STS  = 5'h0F;
  localparam logic [4:0] IX_GCTL = 5'h10;
endpackage

// File: rtl/bd_rx_dma_regs.sv
`timescale 1ns/1ps
module bd_rx_dma_regs
  import bd_rx_dma_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [4:0]         reg_idx,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq,
  input  logic               eng_busy,
  input  logic               eng_adv,
  input  logic [DW-1:0]      eng_next,
  input  logic [NUM_EVT-1:0] eng_evt,
  output logic [DW-1:0]      cur_ptr,
  output logic [DW-1:0]      tail_ptr,
  output logic               start,
  output logic               srst
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic [DW-1:0]      cur_q, cur_d, tail_q, tail_d;
  logic [NUM_EVT-1:0] ctl_q, ctl_d, pend_q, pend_d;
  logic [2:0]         mode_q, mode_d;
  logic               err_q, err_d;
  logic [RCW-1:0]     rcnt_q, rcnt_d;
  logic               rst_busy, rst_req, wr_ok;

  assign rst_busy = (rcnt_q != '0);
  assign wr_ok    = reg_wr && !rst_busy;
  assign rst_req  = wr_ok && (reg_idx == IX_GCTL) && reg_wdata[0];
  assign srst     = rst_req || rst_busy;
  assign start    = wr_ok && (reg_idx == IX_TAIL) && mode_q[0] && !err_q && !eng_busy;

  always_comb begin
    cur_d  = cur_q;
    tail_d = tail_q;
    ctl_d  = ctl_q;
    pend_d = pend_q | eng_evt;
    err_d  = err_q | eng_evt[EV_ERR];
    mode_d = mode_q;
    rcnt_d = rst_busy ? rcnt_q - RCW'(1) : rcnt_q;
    if (eng_adv) cur_d = eng_next;
    if (wr_ok) begin
      case (reg_idx)
        IX_CUR:  if (!eng_busy) cur_d = reg_wdata;
        IX_TAIL: tail_d = reg_wdata;
        IX_CTL:  ctl_d = reg_wdata[NUM_EVT-1:0];
        IX_PEND: pend_d = (pend_q & ~reg_wdata[NUM_EVT-1:0]) | eng_evt;
        IX_GCTL: if (reg_wdata[0]) rcnt_d = RCW'(RST_CYCLES);
                 else mode_d = reg_wdata[4:2];
        default: ;
      endcase
    end
    if (srst) begin
      cur_d  = '0;
      tail_d = '0;
      ctl_d  = '0;
      pend_d = '0;
      err_d  = 1'b0;
      mode_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tail_q <= '0;
      ctl_q  <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
      mode_q <= '0;
      rcnt_q <= '0;
    end else begin
      cur_q  <= cur_d;
      tail_q <= tail_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      mode_q <= mode_d;
      rcnt_q <= rcnt_d;
    end
  end

  always_comb begin
    case (reg_idx)
      IX_CUR:  reg_rdata = cur_q;
      IX_TAIL: reg_rdata = tail_q;
      IX_CTL:  reg_rdata = DW'(ctl_q);
      IX_PEND: reg_rdata = DW'(pend_q);
      IX_STS:  reg_rdata = DW'({err_q, 5'b0, eng_busy, 1'b0});
      IX_GCTL: reg_rdata = DW'({mode_q, 1'b0, rst_busy});
      default: reg_rdata = '0;
    endcase
  end

  assign irq      = |(pend_q & ctl_q);
  assign cur_ptr  = cur_q;
  assign tail_ptr = tail_q;
endmodule

// File: rtl/bd_rx_dma_engine.sv
`timescale 1ns/1ps
module bd_rx_dma_engine
  import bd_rx_dma_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LEN_BITS = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               start,
  input  logic [DW-1:0]      cur_ptr,
  input  logic [DW-1:0]      tail_ptr,
  output logic               busy,
  output logic               adv,
  output logic [DW-1:0]      next_ptr,
  output logic [NUM_EVT-1:0] evt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DW-1:0]      s_data,
  input  logic               s_last
);
  localparam int WCW = LEN_BITS - 2;

  eng_state_e     st_q, st_d;
  logic [1:0]     idx_q, idx_d;
  logic [DW-1:0]  nxt_q, nxt_d, buf_q, buf_d;
  logic [WCW-1:0] cap_q, cap_d, wcnt_q, wcnt_d, fcnt_q, fcnt_d;
  logic           sop_q, sop_d, eop_q, eop_d;
  logic [7:0]     stat;
  logic           unused_rd;

  assign unused_rd = ^{mem_rdata[DW-1:LEN_BITS], mem_rdata[1:0]};
  assign stat = BD_DONE | (sop_q ? BD_SOP : 8'h00) | (eop_q ? BD_EOP : 8'h00);
  assign busy = (st_q != ST_IDLE);
  assign next_ptr = nxt_q;

  always_comb begin
    st_d = st_q; idx_d = idx_q; nxt_d = nxt_q; buf_d = buf_q; cap_d = cap_q;
    wcnt_d = wcnt_q; fcnt_d = fcnt_q; sop_d = sop_q; eop_d = eop_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur_ptr; mem_wdata = '0;
    s_ready = 1'b0; adv = 1'b0; evt = '0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (cur_ptr[BD_ALIGN_BITS-1:0] != '0) evt[EV_ERR] = 1'b1;
        else begin st_d = ST_FETCH; idx_d = 2'd0; end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + DW'({idx_q, 2'b00});
        if (mem_ack) begin
          case (idx_q)
            2'd0:    nxt_d = mem_rdata;
            2'd1:    buf_d = mem_rdata;
            2'd2:    cap_d = mem_rdata[LEN_BITS-1:2];
            default: ;
          endcase
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) begin st_d = ST_MOVE; wcnt_d = '0; eop_d = 1'b0; end
        end
      end
      ST_MOVE: begin
        mem_req   = s_valid;
        mem_we    = 1'b1;
        mem_addr  = buf_q + DW'({wcnt_q, 2'b00});
        mem_wdata = s_data;
        s_ready   = mem_ack;
        if (s_valid && mem_ack) begin
          wcnt_d = wcnt_q + WCW'(1);
          fcnt_d = fcnt_q + WCW'(1);
          if (s_last) begin eop_d = 1'b1; st_d = ST_WBLEN; end
          else if (wcnt_q + WCW'(1) == cap_q) st_d = ST_WBLEN;
        end
      end
      ST_WBLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + DW'(OFS_LENW);
        mem_wdata = DW'({fcnt_q, 2'b00});
        if (mem_ack) st_d = ST_WBSTS;
      end
      ST_WBSTS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + DW'(OFS_STAT);
        mem_wdata = {stat, {(DW-8){1'b0}}};
        if (mem_ack) begin
          evt[EV_DESC] = 1'b1;
          if (eop_q) begin evt[EV_FRAME] = 1'b1; sop_d = 1'b1; fcnt_d = '0; end
          else sop_d = 1'b0;
          if (cur_ptr == tail_ptr) begin evt[EV_TAIL] = 1'b1; st_d = ST_IDLE; end
          else begin
            adv = 1'b1;
            if (nxt_q[BD_ALIGN_BITS-1:0] != '0) begin evt[EV_ERR] = 1'b1; st_d = ST_IDLE; end
            else begin st_d = ST_FETCH; idx_d = 2'd0; end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (srst) begin st_d = ST_IDLE; sop_d = 1'b1; fcnt_d = '0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; nxt_q <= '0; buf_q <= '0; cap_q <= '0;
      wcnt_q <= '0; fcnt_q <= '0; sop_q <= 1'b1; eop_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; nxt_q <= nxt_d; buf_q <= buf_d; cap_q <= cap_d;
      wcnt_q <= wcnt_d; fcnt_q <= fcnt_d; sop_q <= sop_d; eop_q <= eop_d;
    end
  end
endmodule

// File: rtl/bd_rx_dma.sv
`timescale 1ns/1ps
module bd_rx_dma
  import bd_rx_dma_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LEN_BITS   = 14,
  parameter int RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [4:0]    reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_last
);
  logic               busy_w, adv_w, start_w, srst_w;
  logic [DW-1:0]      next_w, cur_w, tail_w;
  logic [NUM_EVT-1:0] evt_w;

  bd_rx_dma_regs #(.DW(DW), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_busy(busy_w), .eng_adv(adv_w), .eng_next(next_w), .eng_evt(evt_w),
    .cur_ptr(cur_w), .tail_ptr(tail_w), .start(start_w), .srst(srst_w)
  );

  bd_rx_dma_engine #(.DW(DW), .LEN_BITS(LEN_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .srst(srst_w), .start(start_w),
    .cur_ptr(cur_w), .tail_ptr(tail_w), .busy(busy_w), .adv(adv_w),
    .next_ptr(next_w), .evt(evt_w), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last)
  );
endmodule

// File: rtl/bd_rx_dma_chk.sv
`timescale 1ns/1ps
module bd_rx_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       srst,
  input logic       start,
  input logic [4:0] cur_lo,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] mem_addr_lo,
  input logic       s_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R9
  AST_READY_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (mem_req && mem_we)); // R5
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr_lo == 2'b00)); // R4
  AST_SRST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy); // R10
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !srst && cur_lo == 5'd0) |=> busy); // R3
endmodule

bind bd_rx_dma bd_rx_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .srst(srst_w), .start(start_w),
  .cur_lo(cur_w[4:0]), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr_lo(mem_addr[1:0]), .s_ready(s_ready)
);

// File: tb/bd_rx_dma_bench.sv
`timescale 1ns/1ps
module bd_rx_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_we, mem_ack, s_valid, s_ready, s_last;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, s_data;
  logic [31:0] mem [0:255];
  logic        gate, tb_we;
  logic [7:0]  tb_wi;
  logic [31:0] tb_wd;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bd_rx_dma u_bd_rx_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last)
  );

  assign mem_ack   = mem_req & gate;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) gate <= 1'b0; else gate <= ~gate;

  always @(posedge clk)
    if (tb_we) mem[tb_wi] <= tb_wd;
    else if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] d);
    @(negedge clk); reg_idx = idx; #1; d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wi = byte_addr[9:2]; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                          input logic [31:0] bufa, input logic [31:0] len);
    poke(a, nxt); poke(a + 4, bufa); poke(a + 8, len);
    poke(a + 12, 32'h0); poke(a + 28, 32'h0);
  endtask

  task automatic push(input logic [31:0] d, input logic last);
    @(negedge clk); s_valid = 1'b1; s_data = d; s_last = last;
    forever begin
      #1;
      if (s_ready) begin @(posedge clk); break; end
      @(posedge clk); @(negedge clk);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(5'h0F, v);
      if (v[1] == 1'b0) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h0B, v); check("R1 cur", v, 0);
    rd(5'h0C, v); check("R1 tail", v, 0);
    rd(5'h0D, v); check("R1 ctl", v, 0);
    rd(5'h0E, v); check("R1 pend", v, 0);
    rd(5'h0F, v); check("R1 sts", v, 0);
    rd(5'h10, v); check("R1 gctl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_mode_off();
    logic [31:0] v;
    put_desc(32'h40, 32'h40, 32'h100, 32'd16);
    wr(5'h0B, 32'h40); rd(5'h0B, v); check("R2 cur readback", v, 32'h40);
    rd(5'h05, v); check("R2 unmapped index", v, 0);
    wr(5'h0C, 32'h40); rd(5'h0F, v); check("R3 no start without tail mode", v, 0);
    check("R3 descriptor untouched", mem[8'h13], 0);
    wr(5'h10, 32'h1C); rd(5'h10, v); check("R11 gctl bits", v, 32'h1C);
  endtask

  task automatic t_single();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) poke(32'h100 + 4*i, 32'h0);
    wr(5'h0D, 32'h1F);
    wr(5'h0C, 32'h40);
    rd(5'h0F, v); check("R3 busy after tail write", v, 32'h2);
    push(32'hA0A0_0000, 1'b0); push(32'hA1A1_0001, 1'b0); push(32'hA2A2_0002, 1'b1);
    wait_idle();
    check("R5 buf w0", mem[8'h40], 32'hA0A0_0000);
    check("R5 buf w1", mem[8'h41], 32'hA1A1_0001);
    check("R5 buf w2", mem[8'h42], 32'hA2A2_0002);
    check("R5 buf w3 untouched", mem[8'h43], 0);
    check("R6 length word", mem[8'h17], 32'd12);
    check("R6 status single", mem[8'h13], 32'h1C00_0000);
    check("R4 next word kept", mem[8'h10], 32'h40);
    rd(5'h0B, v); check("R7 cur on tail", v, 32'h40);
    rd(5'h0E, v); check("R8 pend", v, 32'h07);
    #1; check("R8 irq", {31'b0, irq}, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(5'h0E, 32'h01); rd(5'h0E, v); check("R8 w1c", v, 32'h06);
    wr(5'h0D, 32'h01); #1; check("R8 irq masked", {31'b0, irq}, 0);
    wr(5'h0D, 32'h04); #1; check("R8 irq enabled", {31'b0, irq}, 1);
    wr(5'h0E, 32'h1F); rd(5'h0E, v); check("R8 clear all", v, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    put_desc(32'h40, 32'h60, 32'h100, 32'd8);
    put_desc(32'h60, 32'h80, 32'h140, 32'd8);
    put_desc(32'h80, 32'h80, 32'h180, 32'd8);
    for (int i = 0; i < 2; i++) poke(32'h144 + 4*i, 32'h0);
    wr(5'h0B, 32'h40); wr(5'h0C, 32'h60);
    push(32'hB0, 1'b0); push(32'hB1, 1'b0); push(32'hB2, 1'b1);
    wait_idle();
    check("R5 chain A w0", mem[8'h40], 32'hB0);
    check("R5 chain A w1", mem[8'h41], 32'hB1);
    check("R5 chain B w0", mem[8'h50], 32'hB2);
    check("R5 chain B w1 untouched", mem[8'h51], 0);
    check("R6 A status sop", mem[8'h13], 32'h1800_0000);
    check("R6 A count", mem[8'h17], 32'd8);
    check("R6 B status eop", mem[8'h1B], 32'h1400_0000);
    check("R6 B count", mem[8'h1F], 32'd12);
    check("R7 past tail untouched", mem[8'h23], 0);
    rd(5'h0B, v); check("R7 cur advanced", v, 32'h60);
    rd(5'h0E, v); check("R8 chain pend", v, 32'h07);
  endtask

  task automatic t_align();
    logic [31:0] v;
    wr(5'h0E, 32'h1F);
    poke(32'h50, 32'h0);
    wr(5'h0B, 32'h44); wr(5'h0C, 32'h44);
    rd(5'h0F, v); check("R9 error status", v, 32'h80);
    rd(5'h0E, v); check("R9 error pending", v, 32'h10);
    check("R9 no access", mem[8'h14], 0);
    wr(5'h0B, 32'h40); wr(5'h0C, 32'h40);
    rd(5'h0F, v); check("R9 sticky blocks start", v, 32'h80);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(5'h10, 32'h01); wr(5'h0C, 32'h60);
    rd(5'h10, v); check("R10 bit0 during reset", v, 32'h1);
    repeat (8) @(negedge clk);
    rd(5'h10, v); check("R10 bit0 cleared", v, 0);
    rd(5'h0F, v); check("R10 error cleared", v, 0);
    rd(5'h0C, v); check("R10 write ignored", v, 0);
    put_desc(32'h40, 32'h40, 32'h100, 32'd16);
    wr(5'h10, 32'h04); wr(5'h0B, 32'h40); wr(5'h0C, 32'h40);
    rd(5'h0F, v); check("R3 busy", v, 32'h2);
    wr(5'h0B, 32'h80); rd(5'h0B, v); check("R2 cur held while busy", v, 32'h40);
    wr(5'h10, 32'h01);
    rd(5'h0F, v); check("R10 halts engine", v, 0);
    rd(5'h0B, v); check("R10 cur cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    tb_we = 1'b0; tb_wi = '0; tb_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) poke(32'(i * 4), 32'h0);
    t_reset();
    t_mode_off();
    t_single();
    t_w1c();
    t_chain();
    t_align();
    t_srst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule